// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is one 8-bit input channel that a peripheral loads with a strobe handshake. The peripheral puts a byte on the data pins and pulls its active-low strobe down. The port captures that byte and raises a buffer-full flag so the peripheral knows it has been taken. Once the strobe is released, the port asks the processor for service with an interrupt request, provided the interrupt enable is set. The processor then reads the byte with an active-low read strobe. The falling edge of the read strobe withdraws the interrupt. The rising edge ends the transfer by clearing buffer-full.

Every handshake line is asynchronous to the system clock. Each goes through a synchronizer of `SYNC_STAGES` flops, and its edges are found in the clock domain. The data pins go through a delay line of the same depth, so the byte captured is the one on the pins in the clock cycle where the strobe was first sampled low. The enable input is a level that is synchronous to the clock. It normally comes from a per-port bit that is set or cleared by a bit-manipulation command elsewhere. Every handshake pulse, high or low, must span at least one rising clock edge.

Top module: `sip_strobed_input`

## Requirements
- R1: While `rst_n` is low, and after it is released with the strobes idle, `ibf_o`, `intr_o` and `data_o` are all 0.
- R2: A falling edge on `stb_n_i` sets `ibf_o` to 1 and loads `data_o` with the value `port_data_i` had when the strobe was first sampled low. Both become visible exactly `SYNC_STAGES`+1 rising clock edges after the pin goes low.
- R3: `data_o` changes only on a strobe falling edge. Changes to `port_data_i` while the strobe stays low, and any read, leave it unchanged.
- R4: `intr_o` is 0 whenever the synchronized strobe is low. With `ibf_o`=1 and `ie_i`=1, it goes to 1 exactly `SYNC_STAGES`+1 edges after `stb_n_i` rises.
- R5: `intr_o` can be 1 only when `ie_i`=1. With the other inputs steady, a change of `ie_i` shows on `intr_o` one clock edge later.
- R6: `rd_n_i` going low clears `intr_o` within `SYNC_STAGES`+1 edges while `ibf_o` stays 1. `intr_o` stays 0 for as long as the read strobe is low.
- R7: `rd_n_i` rising clears `ibf_o` exactly `SYNC_STAGES`+1 edges later, and `intr_o` stays 0.
- R8: A second strobe that arrives while `ibf_o` is still 1 overwrites `data_o` with the new byte, and `ibf_o` stays 1.
- R9: If a strobe falling edge and a read rising edge reach the synchronized domain in the same cycle, the new byte is loaded and `ibf_o` stays 1.
- R10: A read pulse while `ibf_o` is 0 changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_data_i | input | DATA_W | Byte driven by the peripheral |
| stb_n_i | input | 1 | Active-low peripheral strobe (asynchronous) |
| rd_n_i | input | 1 | Active-low processor read strobe for this port (asynchronous) |
| ie_i | input | 1 | Interrupt enable level (clock-synchronous) |
| data_o | output | DATA_W | Captured byte |
| ibf_o | output | 1 | Input buffer full flag |
| intr_o | output | 1 | Interrupt request to the processor |

## Verification
The directed patterns separate the two read edges. After the read strobe falls, the interrupt must be low while buffer-full is still high. They also time each edge to the exact clock, which catches a synchronizer or capture stage that is too deep or too shallow.

Further directed patterns cover:
- a strobe that overlaps a read release, which shows whether set or clear wins;
- back-to-back strobes with no read between them, which shows overwrite;
- a read with an empty buffer, which must do nothing;
- data changing under a held strobe, which shows whether capture is taken from the edge or from the level.

Seeded random sequences of strobes, reads and enable flips then compare all three outputs against a bench model after each settled step.

// File: rtl/sip_pkg.sv
package sip_pkg;

  // Which edge a synchronizer instance reports.
  typedef enum logic [0:0] {
    SIP_EDGE_FALL = 1'b0,
    SIP_EDGE_RISE = 1'b1
  } sip_edge_e;

  // Cycles from a pin change to the registered outputs.
  function automatic int sip_latency(input int stages);
    return stages + 1;
  endfunction

  // Buffer-full next state: a new capture wins over a read completion.
  function automatic logic sip_ibf_next(input logic cur, input logic set, input logic clr);
    logic nxt;
    nxt = cur;
    if (clr) nxt = 1'b0;
    if (set) nxt = 1'b1;
    return nxt;
  endfunction

  // Interrupt request: only with data held, strobe released, no read in progress, enabled.
  function automatic logic sip_intr_next(input logic full, input logic stb_idle,
                                         input logic rd_idle, input logic en);
    return full & stb_idle & rd_idle & en;
  endfunction

endpackage

// File: rtl/sip_sync_edge.sv
module sip_sync_edge
  import sip_pkg::*;
#(
  parameter int        STAGES  = 2,
  parameter logic      IDLE    = 1'b1,
  parameter sip_edge_e EDGE    = SIP_EDGE_FALL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= IDLE;
          else        chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= IDLE;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= chain_q[LAST];
  end

  assign level_o = chain_q[LAST];

  generate
    if (EDGE == SIP_EDGE_RISE) begin : g_rise
      assign edge_o = chain_q[LAST] & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~chain_q[LAST] & prev_q;
    end
  endgenerate

  // An edge is only reported when the synchronized level differs from the last one.
  AST_EDGE_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (level_o != prev_q)); // R2

endmodule

// File: rtl/sip_delay_pipe.sv
module sip_delay_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] pipe_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= '0;
          else        pipe_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= '0;
          else        pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[LAST];

endmodule

// File: rtl/sip_capture_reg.sv
module sip_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (load_i) hold_q <= d_i;
  end

  assign q_o = hold_q;

  AST_DATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o)); // R3
  AST_DATA_TAKES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(d_i))); // R2

endmodule

// File: rtl/sip_handshake_ctrl.sv
module sip_handshake_ctrl
  import sip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb_fall_i,
  input  logic stb_hi_i,
  input  logic rd_rise_i,
  input  logic rd_hi_i,
  input  logic ie_i,
  output logic ibf_o,
  output logic intr_o
);

  logic ibf_q, ibf_d;
  logic intr_q, intr_d;

  always_comb begin
    ibf_d  = sip_ibf_next(ibf_q, stb_fall_i, rd_rise_i);
    intr_d = sip_intr_next(ibf_d, stb_hi_i, rd_hi_i, ie_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q  <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      ibf_q  <= ibf_d;
      intr_q <= intr_d;
    end
  end

  assign ibf_o  = ibf_q;
  assign intr_o = intr_q;

  AST_IBF_SET_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall_i |=> ibf_q); // R2
  AST_IBF_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise_i && !stb_fall_i) |=> !ibf_q); // R7
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise_i && stb_fall_i) |=> ibf_q); // R9
  AST_INTR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    intr_q |-> ibf_q); // R4
  AST_INTR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    intr_q |-> $past(ie_i)); // R5
  AST_STROBE_LOW_NO_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_hi_i |=> !intr_q); // R4
  AST_READ_LOW_NO_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hi_i |=> !intr_q); // R6
  AST_EMPTY_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ibf_q && !stb_fall_i) |=> !ibf_q); // R10

endmodule

// File: rtl/sip_strobed_input.sv
module sip_strobed_input
  import sip_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] port_data_i,
  input  logic              stb_n_i,
  input  logic              rd_n_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ibf_o,
  output logic              intr_o
);

  // Named internal events, brought out for the checks.
  logic              stb_hi_w;
  logic              stb_fall_w;
  logic              rd_hi_w;
  logic              rd_rise_w;
  logic [DATA_W-1:0] data_aligned_w;

  sip_sync_edge #(
    .STAGES (SYNC_STAGES),
    .IDLE   (1'b1),
    .EDGE   (SIP_EDGE_FALL)
  ) stb_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (stb_n_i),
    .level_o (stb_hi_w),
    .edge_o  (stb_fall_w)
  );

  sip_sync_edge #(
    .STAGES (SYNC_STAGES),
    .IDLE   (1'b1),
    .EDGE   (SIP_EDGE_RISE)
  ) rd_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (rd_n_i),
    .level_o (rd_hi_w),
    .edge_o  (rd_rise_w)
  );

  // Data follows the strobe through the same depth so capture lines up.
  sip_delay_pipe #(
    .W      (DATA_W),
    .STAGES (SYNC_STAGES)
  ) data_pipe_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (port_data_i),
    .q_o   (data_aligned_w)
  );

  sip_capture_reg #(
    .W (DATA_W)
  ) capture_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (stb_fall_w),
    .d_i    (data_aligned_w),
    .q_o    (data_o)
  );

  sip_handshake_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_fall_i (stb_fall_w),
    .stb_hi_i   (stb_hi_w),
    .rd_rise_i  (rd_rise_w),
    .rd_hi_i    (rd_hi_w),
    .ie_i       (ie_i),
    .ibf_o      (ibf_o),
    .intr_o     (intr_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ibf_o && !intr_o)); // R1
  AST_LOAD_RAISES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall_w |=> (ibf_o && data_o == $past(data_aligned_w))); // R8

endmodule

// File: tb/sip_strobed_input_tb_top.sv
`timescale 1ns/1ps
module sip_strobed_input_tb_top;

  localparam int DATA_W = 8;
  localparam int SYNC   = 2;
  localparam int LAT    = SYNC + 1;
  localparam real CLK_P = 20.0;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DATA_W-1:0] port_data;
  logic              stb_n, rd_n, ie;
  logic [DATA_W-1:0] data_o;
  logic              ibf_o, intr_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Bench model state
  logic [DATA_W-1:0] m_data;
  logic              m_full;

  always #(CLK_P/2) clk = ~clk;

  sip_strobed_input #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_data_i(port_data), .stb_n_i(stb_n),
    .rd_n_i(rd_n), .ie_i(ie), .data_o(data_o), .ibf_o(ibf_o), .intr_o(intr_o)
  );

  // Request is raised only when every condition for it holds at once.
  function automatic logic want_irq(input logic full, input logic en,
                                    input logic strobe_n, input logic read_n);
    if (!en || !full) return 1'b0;
    if (!strobe_n) return 1'b0;
    return read_n;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_model(input string req);
    chk({req, " data"}, 32'(data_o), 32'(m_data));
    chk({req, " ibf"},  32'(ibf_o),  32'(m_full));
    chk({req, " intr"}, 32'(intr_o), 32'(want_irq(m_full, ie, stb_n, rd_n)));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0; stb_n = 1'b1; rd_n = 1'b1; ie = 1'b0; port_data = '0;
    m_data = '0; m_full = 1'b0;
    seed = $urandom(32'd20240611);
    tick(3);
    // R1: outputs held at zero during reset
    chk("R1 ibf in reset", 32'(ibf_o), 0);
    chk("R1 intr in reset", 32'(intr_o), 0);
    chk("R1 data in reset", 32'(data_o), 0);
    rst_n = 1'b1;
    tick(4);
    chk_model("R1 after release");

    ie = 1'b1;
    tick(1);

    // R2: exact capture latency
    port_data = 8'hA5;
    stb_n = 1'b0;
    tick(LAT - 1);
    chk("R2 ibf before latency", 32'(ibf_o), 0);
    tick(1);
    chk("R2 ibf at latency", 32'(ibf_o), 1);
    chk("R2 data at latency", 32'(data_o), 32'hA5);
    m_data = 8'hA5; m_full = 1'b1;
    // R3: data moving under a held strobe is ignored
    port_data = 8'h3C;
    tick(3);
    chk("R3 data held under low strobe", 32'(data_o), 32'hA5);
    // R4: request held back until strobe rises, exact latency
    chk("R4 intr while strobe low", 32'(intr_o), 0);
    stb_n = 1'b1;
    tick(LAT - 1);
    chk("R4 intr before latency", 32'(intr_o), 0);
    tick(1);
    chk("R4 intr at latency", 32'(intr_o), 1);

    // R5: enable gates the request with one edge of delay
    ie = 1'b0;
    tick(1);
    chk("R5 intr after disable", 32'(intr_o), 0);
    chk("R5 ibf kept", 32'(ibf_o), 1);
    ie = 1'b1;
    tick(1);
    chk("R5 intr after enable", 32'(intr_o), 1);

    // R6: read falling clears intr, ibf remains
    rd_n = 1'b0;
    tick(LAT);
    chk("R6 intr after read low", 32'(intr_o), 0);
    chk("R6 ibf during read", 32'(ibf_o), 1);
    tick(3);
    chk("R6 intr stays low", 32'(intr_o), 0);
    chk("R3 data during read", 32'(data_o), 32'hA5);
    // R7: read rising clears ibf at exact latency
    rd_n = 1'b1;
    tick(LAT - 1);
    chk("R7 ibf before latency", 32'(ibf_o), 1);
    tick(1);
    chk("R7 ibf at latency", 32'(ibf_o), 0);
    chk("R7 intr after read", 32'(intr_o), 0);
    m_full = 1'b0;

    // R10: read with empty buffer does nothing
    rd_n = 1'b0;
    tick(LAT + 1);
    chk_model("R10 read low empty");
    rd_n = 1'b1;
    tick(LAT + 1);
    chk_model("R10 read high empty");

    // R8: second strobe overwrites
    port_data = 8'h11; stb_n = 1'b0; tick(3); stb_n = 1'b1; tick(4);
    m_data = 8'h11; m_full = 1'b1;
    chk_model("R8 first byte");
    port_data = 8'h22; stb_n = 1'b0; tick(3); stb_n = 1'b1; tick(4);
    m_data = 8'h22;
    chk_model("R8 overwrite");

    // R9: read release and new strobe in the same cycle
    rd_n = 1'b0;
    tick(4);
    port_data = 8'h77;
    rd_n = 1'b1; stb_n = 1'b0;
    tick(LAT + 1);
    m_data = 8'h77; m_full = 1'b1;
    chk("R9 ibf kept", 32'(ibf_o), 1);
    chk("R9 data new", 32'(data_o), 32'h77);
    stb_n = 1'b1;
    tick(LAT + 1);
    chk_model("R9 after strobe");

    // Seeded random sequence
    for (int it = 0; it < 80; it++) begin
      int act;
      int len;
      logic [DATA_W-1:0] d;
      act = int'($urandom % 3);
      len = 3 + int'($urandom % 4);
      d   = DATA_W'($urandom);
      if (act == 0) begin
        port_data = d; stb_n = 1'b0;
        tick(len);
        chk("R4 random intr under strobe", 32'(intr_o), 0);
        chk("R2 random capture", 32'(data_o), 32'(d));
        port_data = ~d;
        stb_n = 1'b1;
        tick(LAT + 1);
        m_data = d; m_full = 1'b1;
        chk_model("R2 random strobe");
      end else if (act == 1) begin
        rd_n = 1'b0;
        tick(len);
        chk("R6 random intr under read", 32'(intr_o), 0);
        chk("R6 random ibf under read", 32'(ibf_o), 32'(m_full));
        rd_n = 1'b1;
        tick(LAT + 1);
        m_full = 1'b0;
        chk_model("R7 random read");
      end else begin
        ie = ~ie;
        tick(1);
        chk_model("R5 random enable");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule